// File: doc/BRIEF.md
# Misaligned Access Splitting Bus Sequencer

This block sits between a load/store unit and an external data bus that runs four byte lanes wide. It takes one access at a time. Each access has a byte address, a size of 1, 2, 4 or 8 bytes, a direction and, for stores, up to eight bytes of data. The block turns the access into one or two bus transactions. For each transaction it drives a 3-bit transfer-size code, the address and a lane enable mask, and it waits for an acknowledge before moving on.

An access that fits inside one aligned 4-byte word goes out as a single transaction. An access that crosses a word boundary is split. The first part covers the bytes from the start offset to the end of the word. The second part starts at the next word, and that word may lie in the next doubleword with a carry into the upper address bits. A doubleword access goes out as two beats, each on all four lanes. Store bytes are rotated onto the lanes of each transaction. Load bytes are gathered back into a right-aligned result.

Top module: `misalign_seq`

## Requirements
- R1: During reset and on the first cycle after it, `bus_valid` and `done` are 0 and `req_ready` is 1.
- R2: `req_size` codes are 0 for one byte, 1 for two, 2 for four and 3 for eight. The transfer-size code `bus_tsiz` is 001, 010, 011 or 100 for 1, 2, 3 or 4 bytes and 000 for a doubleword. An access whose bytes fit in one aligned word is one transaction at `req_addr`, with lanes offset..offset+n-1 enabled, where offset is `req_addr[1:0]`.
- R3: An access that crosses a word boundary first issues 4-offset bytes at `req_addr`, on lanes offset..3.
- R4: The second part of a split access is issued at the next word address (`req_addr[ADDR_W-1:2]`+1, low bits 00, with carry and wrap through all upper bits). Its size is the remaining byte count, on lanes starting at lane 0.
- R5: A size-3 access ignores `req_addr[2:0]`. It issues two beats, each with `bus_tsiz`=000, the address low three bits 000 and all four lanes enabled. Beat 0 carries bytes 0-3 and beat 1 carries bytes 4-7.
- R6: A transaction holds `bus_valid`, `bus_addr`, `bus_tsiz` and `bus_lanes` steady until `bus_ack`. The next transaction appears on the cycle after that acknowledge.
- R7: `req_ready` is high only when no access is in progress, and a `req_valid` seen while busy is ignored. `done` pulses for exactly one cycle, on the cycle after the final acknowledge.
- R8: Lane i is `bus_rdata[8i+7:8i]`. When `done` pulses for a load, byte k of `rdata` (bits 8k+7:8k) holds the byte returned for address `req_addr`+k (aligned base for size 3). Bytes beyond the size are 0, and data on disabled lanes is ignored.
- R9: For a store, each enabled lane i of `bus_wdata` carries byte k of `req_wdata`, where k is the byte's position from the start of the access. Disabled lanes are driven 0, and `bus_write` follows the request direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Idle, request will be taken |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 64 | Store bytes, byte 0 in bits 7:0 |
| bus_valid | output | 1 | Transaction presented |
| bus_write | output | 1 | Direction of the transaction |
| bus_tsiz | output | 3 | Transfer-size code |
| bus_addr | output | ADDR_W | Transaction address |
| bus_lanes | output | 4 | Lane enables, bit i = lane i |
| bus_wdata | output | 32 | Store data on lanes |
| bus_rdata | input | 32 | Load data on lanes |
| bus_ack | input | 1 | Transaction complete |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Assembled load data |

## Verification
A request taken at one rising edge puts the first transaction on the bus at the next edge, so the bench reads the transaction fields at the falling edge after its request cycle. A second part or beat appears one edge after the acknowledge, and the bench samples it at the falling edge that follows. `done` and `rdata` are read at the falling edge just after the final acknowledge, and one falling edge later the bench checks that `done` has dropped. While the acknowledge is held back for a random number of cycles, the bench samples the fields on every falling edge to confirm they stay steady.

// File: rtl/misalign_seq.sv
module misalign_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [63:0]       req_wdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [2:0]        bus_tsiz,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_lanes,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              done,
  output logic [63:0]       rdata
);

  logic              busy, phase, wr_q, done_q;
  logic [ADDR_W-1:0] a_q;
  logic [1:0]        sz_q;
  logic [63:0]       wd_q, rd_q;

  logic              dword, split, last;
  logic [1:0]        off;
  logic [3:0]        nbytes;
  logic [2:0]        room, n1, n2, cnt, base, lane_off;
  logic [ADDR_W-1:0] nxt_word;
  logic [2:0]        lane_idx [4];

  assign off      = a_q[1:0];
  assign dword    = (sz_q == 2'd3);
  assign nbytes   = 4'd1 << sz_q;
  assign room     = 3'd4 - {1'b0, off};
  assign split    = !dword && (nbytes > {1'b0, room});
  assign n1       = split ? room : nbytes[2:0];
  assign n2       = nbytes[2:0] - n1;
  assign last     = (dword || split) ? phase : 1'b1;
  assign lane_off = (phase || dword) ? 3'd0 : {1'b0, off};
  assign cnt      = dword ? 3'd4 : (phase ? n2 : n1);
  assign base     = dword ? {phase, 2'b00} : (phase ? n1 : 3'd0);
  assign nxt_word = {a_q[ADDR_W-1:2] + 1'b1, 2'b00};

  assign req_ready = !busy;
  assign bus_valid = busy;
  assign bus_write = wr_q;
  assign bus_tsiz  = dword ? 3'b000 : cnt;
  assign bus_addr  = dword ? {a_q[ADDR_W-1:3], 3'b000} : (phase ? nxt_word : a_q);
  assign done      = done_q;
  assign rdata     = rd_q;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign bus_lanes[i]        = (3'(i) >= lane_off) && (3'(i) < lane_off + cnt);
    assign lane_idx[i]         = base + 3'(i) - lane_off;
    assign bus_wdata[8*i +: 8] = bus_lanes[i] ? wd_q[8*lane_idx[i] +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      a_q    <= '0;
      sz_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy && req_valid) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        a_q   <= req_addr;
        sz_q  <= req_size;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
        rd_q  <= '0;
      end else if (busy && bus_ack) begin
        for (int i = 0; i < 4; i++)
          if (bus_lanes[i] && !wr_q) rd_q[8*lane_idx[i] +: 8] <= bus_rdata[8*i +: 8];
        if (last) begin
          busy   <= 1'b0;
          phase  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          phase <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/misalign_seq_chk.sv
module misalign_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_valid,
  input logic [2:0]        bus_tsiz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_lanes,
  input logic              bus_ack,
  input logic              done
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !bus_valid && !done && req_ready);

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !bus_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !bus_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_tsiz) && $stable(bus_lanes));

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_tsiz != 3'b000 |-> $countones(bus_lanes) == int'(bus_tsiz));

  // R4
  start_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_lanes[bus_addr[1:0]]);

  // R5
  dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_tsiz == 3'b000 |-> bus_lanes == 4'hF && bus_addr[2:0] == 3'b000);

endmodule

bind misalign_seq misalign_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_valid(bus_valid),
  .bus_tsiz(bus_tsiz), .bus_addr(bus_addr), .bus_lanes(bus_lanes),
  .bus_ack(bus_ack), .done(done)
);

// File: tb/misalign_seq_tb.sv
module misalign_seq_tb;
  localparam int AW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, bus_ack = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [63:0]   req_wdata = '0;
  logic [31:0]   bus_rdata = '0;
  logic          req_ready, bus_valid, bus_write, done;
  logic [2:0]    bus_tsiz;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_lanes;
  logic [31:0]   bus_wdata;
  logic [63:0]   rdata;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  misalign_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_tsiz(bus_tsiz), .bus_addr(bus_addr),
    .bus_lanes(bus_lanes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .done(done), .rdata(rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[31:24] ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic [AW-1:0] addr, logic [1:0] size, bit wr, logic [63:0] wd);
    int            nt, nb, off;
    logic [AW-1:0] e_addr [2];
    logic [2:0]    e_tsiz [2];
    logic [3:0]    e_lane [2];
    int            e_base [2], e_loff [2];
    logic [AW-1:0] dbase;
    logic [63:0]   e_rd;
    nb  = 1 << size;
    off = int'(addr[1:0]);
    dbase = {addr[AW-1:3], 3'b000};
    if (size == 2'd3) begin
      nt = 2;
      for (int t = 0; t < 2; t++) begin
        e_addr[t] = dbase; e_tsiz[t] = 3'b000; e_lane[t] = 4'hF;
        e_base[t] = 4 * t; e_loff[t] = 0;
      end
    end else if (off + nb <= 4) begin
      nt = 1;
      e_addr[0] = addr; e_tsiz[0] = 3'(nb); e_lane[0] = 4'(((1 << nb) - 1) << off);
      e_base[0] = 0; e_loff[0] = off;
    end else begin
      nt = 2;
      e_addr[0] = addr; e_tsiz[0] = 3'(4 - off); e_lane[0] = 4'(((1 << (4 - off)) - 1) << off);
      e_base[0] = 0; e_loff[0] = off;
      e_addr[1] = {addr[AW-1:2] + 30'd1, 2'b00}; e_tsiz[1] = 3'(nb - 4 + off);
      e_lane[1] = 4'((1 << (nb - 4 + off)) - 1);
      e_base[1] = 4 - off; e_loff[1] = 0;
    end
    e_rd = '0;
    if (!wr)
      for (int k = 0; k < nb; k++)
        e_rd[8*k +: 8] = mem_byte(((size == 2'd3) ? dbase : addr) + AW'(k));

    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = addr; req_size = size; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < nt; t++) begin
      logic [31:0] e_wd;
      int          d;
      chk(bus_valid === 1'b1, "R6 transaction presented", 64'(bus_valid), 64'd1);
      chk(bus_write === wr, "R9 direction", 64'(bus_write), 64'(wr));
      chk(bus_tsiz === e_tsiz[t], (t == 0) ? "R2/R3 size code" : "R4/R5 second size code",
          64'(bus_tsiz), 64'(e_tsiz[t]));
      chk(bus_addr === e_addr[t], (t == 0) ? "R3 first address" : "R4 second address",
          64'(bus_addr), 64'(e_addr[t]));
      chk(bus_lanes === e_lane[t], (size == 2'd3) ? "R5 lanes" : "R2 lanes",
          64'(bus_lanes), 64'(e_lane[t]));
      if (wr) begin
        e_wd = '0;
        for (int i = 0; i < 4; i++)
          if (e_lane[t][i]) e_wd[8*i +: 8] = wd[8*(e_base[t] + i - e_loff[t]) +: 8];
        chk(bus_wdata === e_wd, "R9 store lanes", 64'(bus_wdata), 64'(e_wd));
      end
      d = int'($urandom % 4);
      for (int w = 0; w < d; w++) begin
        if (w == 0) begin
          req_valid = 1'b1; req_addr = addr ^ 32'h0000_0F0C; req_size = 2'd2;
        end
        @(negedge clk);
        chk(bus_valid === 1'b1 && bus_addr === e_addr[t] && bus_tsiz === e_tsiz[t]
            && bus_lanes === e_lane[t], "R6 hold until ack", 64'(bus_addr), 64'(e_addr[t]));
        chk(req_ready === 1'b0 && done === 1'b0, "R7 busy ignores request",
            64'({req_ready, done}), 64'd0);
      end
      for (int i = 0; i < 4; i++) begin
        if (size == 2'd3) bus_rdata[8*i +: 8] = mem_byte({dbase[AW-1:3], 1'(t), 2'(i)});
        else if (e_lane[t][i]) bus_rdata[8*i +: 8] = mem_byte({e_addr[t][AW-1:2], 2'(i)});
        else bus_rdata[8*i +: 8] = 8'hEE;
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      req_valid = 1'b0;
    end
    chk(done === 1'b1, "R7 done after final ack", 64'(done), 64'd1);
    chk(rdata === e_rd, "R8 load result", rdata, e_rd);
    @(negedge clk);
    chk(done === 1'b0 && bus_valid === 1'b0, "R7 single done pulse", 64'({done, bus_valid}), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(bus_valid === 1'b0 && done === 1'b0 && req_ready === 1'b1, "R1 reset state",
        64'({bus_valid, done, req_ready}), 64'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_valid === 1'b0 && req_ready === 1'b1, "R1 after reset", 64'({bus_valid, req_ready}), 64'b01);

    access(32'h0000_0103, 2'd0, 1'b0, '0);
    access(32'h0000_0102, 2'd1, 1'b0, '0);
    access(32'h0000_0106, 2'd1, 1'b1, 64'h0000_0000_0000_BEEF);
    access(32'h0000_0200, 2'd2, 1'b0, '0);
    access(32'h0000_0204, 2'd2, 1'b1, 64'h0000_0000_1122_3344);
    for (int o = 1; o < 8; o++) begin
      access(32'h0000_0300 + AW'(o), 2'd2, 1'b0, '0);
      access(32'h0000_0300 + AW'(o), 2'd2, 1'b1, 64'h0000_0000_A1B2_C3D4);
    end
    access(32'h0000_0FFE, 2'd2, 1'b0, '0);
    access(32'hFFFF_FFFF, 2'd2, 1'b1, 64'h0000_0000_5566_7788);
    access(32'h0000_0403, 2'd1, 1'b0, '0);
    access(32'h0000_0407, 2'd1, 1'b1, 64'h0000_0000_0000_9A8B);
    access(32'h0000_0500, 2'd3, 1'b0, '0);
    access(32'h0000_0515, 2'd3, 1'b1, 64'h0102_0304_0506_0708);

    for (int n = 0; n < 400; n++)
      access($urandom, 2'($urandom), 1'($urandom), {$urandom, $urandom});

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule